// File: doc/BRIEF.md
# Barrier-Aware Round-Robin Warp Scheduler

This block decides which warp slot of a multithreaded SIMD multiprocessor issues its next instruction. Each slot carries one of three states. Active means the warp is ready to issue. Waiting means it is parked at a block-wide barrier. Inactive means it is not running or has finished. On every cycle in which at least one slot is Active, the block grants exactly one Active slot, and it picks that slot in rotating order.

The issue side reports events for a warp: that the warp executed a synchronization barrier, or that it reached the end-of-kernel marker. A barrier parks the warp. When no slot is Active and at least one slot is Waiting, every Waiting slot is released back to Active together. A finished warp drops out of rotation for good. When every slot is Inactive, the block raises a request for a new set of thread blocks. A launch with a running-warp mask then loads the next batch.

Top module: `ws_sched`

## Requirements
- R1: After reset every slot is Inactive, `issue_valid` is 0, `refill_req` is 1, `err_sticky` is 0 and the rotation pointer is slot 0.
- R2: In a cycle with `launch_valid`=1, slot i becomes Active if `launch_mask[i]`=1 and Inactive otherwise, and the pointer returns to slot 0. Launch overrides any event or release in that cycle.
- R3: `issue_valid` is 1 exactly when at least one slot is Active. `issue_warp` is then the first Active slot found by searching upward, cyclically, from the pointer.
- R4: After a grant of slot g, the pointer moves to g+1, wrapping from NUM_WARPS-1 to 0.
- R5: An event with `evt_barrier`=1 and `evt_exit`=0 that names an Active slot (`evt_warp`) moves that slot to Waiting on the next cycle.
- R6: When no slot is Active and at least one is Waiting, `barrier_release` is 1 in that cycle, and on the next cycle all Waiting slots are Active.
- R7: An event with `evt_exit`=1 that names an Active slot moves that slot to Inactive on the next cycle. It is never granted again until the next launch.
- R8: An event naming a slot that is not Active, or an index of NUM_WARPS or above, changes no state.
- R9: `refill_req` is 1 exactly when every slot is Inactive.
- R10: `evt_barrier` and `evt_exit` both at 1 in one cycle set `err_sticky`, which stays 1 until reset. If the named slot is Active, the exit effect wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Load a new batch of warps |
| launch_mask | input | NUM_WARPS | Slots that start Active on launch |
| evt_warp | input | IDX_W | Slot the event refers to |
| evt_barrier | input | 1 | Slot executed a block-wide barrier |
| evt_exit | input | 1 | Slot reached the end-of-kernel marker |
| issue_valid | output | 1 | A slot is granted this cycle |
| issue_warp | output | IDX_W | Granted slot index |
| barrier_release | output | 1 | Waiting slots return to Active next cycle |
| refill_req | output | 1 | All slots Inactive; new blocks wanted |
| err_sticky | output | 1 | Conflicting events were seen |

## Verification
A corrupted slot state shows at the grant port within one rotation. A slot that is wrongly Active gets granted out of turn. A slot that is wrongly parked or retired is skipped, and the index sequence then departs from the reference order on the very cycle that slot was due. A missed release appears one cycle later: `issue_valid` stays low while `barrier_release` is high. A wrong pointer shows on the next grant. The bench compares every output on every cycle against a behavioural model, so each of these faults is caught within a few cycles of where it arises.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [1:0] {
        WS_INACTIVE = 2'd0,
        WS_ACTIVE   = 2'd1,
        WS_WAITING  = 2'd2
    } wstate_e;
endpackage

// File: rtl/ws_summary.sv
module ws_summary
    import ws_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0][1:0] st_i,
    output logic [N-1:0]      active_vec_o,
    output logic              any_active_o,
    output logic              any_waiting_o,
    output logic              all_inactive_o
);
    logic [N-1:0] waiting_vec;
    logic [N-1:0] idle_vec;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign active_vec_o[i] = (st_i[i] == WS_ACTIVE);
        assign waiting_vec[i]  = (st_i[i] == WS_WAITING);
        assign idle_vec[i]     = (st_i[i] == WS_INACTIVE);
    end

    assign any_active_o   = |active_vec_o;
    assign any_waiting_o  = |waiting_vec;
    assign all_inactive_o = &idle_vec;
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan offsets from farthest to nearest so the nearest request wins.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int off = N - 1; off >= 0; off--) begin
            int slot;
            slot = int'(ptr_i) + off;
            if (slot >= N) slot = slot - N;
            if (req_i[slot]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(slot);
            end
        end
    end
endmodule

// File: rtl/ws_sched.sv
module ws_sched
    import ws_pkg::*;
#(
    parameter int NUM_WARPS = 32,
    parameter int IDX_W     = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [NUM_WARPS-1:0] launch_mask,
    input  logic [IDX_W-1:0]     evt_warp,
    input  logic                 evt_barrier,
    input  logic                 evt_exit,
    output logic                 issue_valid,
    output logic [IDX_W-1:0]     issue_warp,
    output logic                 barrier_release,
    output logic                 refill_req,
    output logic                 err_sticky
);
    typedef struct packed {
        logic [NUM_WARPS-1:0][1:0] st;
        logic [IDX_W-1:0]          ptr;
        logic                      err;
    } sched_t;

    sched_t cur_q, nxt_d;

    logic [NUM_WARPS-1:0][1:0] st_q;
    logic [IDX_W-1:0]          ptr_q;
    logic [NUM_WARPS-1:0]      active_vec;
    logic                      any_active, any_waiting, all_inactive;
    logic                      grant_v;
    logic [IDX_W-1:0]          grant_idx;
    logic                      evt_in_range;

    assign st_q  = cur_q.st;
    assign ptr_q = cur_q.ptr;

    ws_summary #(.N(NUM_WARPS)) u_sum (
        .st_i           (st_q),
        .active_vec_o   (active_vec),
        .any_active_o   (any_active),
        .any_waiting_o  (any_waiting),
        .all_inactive_o (all_inactive)
    );

    ws_rr_pick #(.N(NUM_WARPS), .IDX_W(IDX_W)) u_pick (
        .req_i   (active_vec),
        .ptr_i   (ptr_q),
        .valid_o (grant_v),
        .idx_o   (grant_idx)
    );

    assign evt_in_range    = (int'(evt_warp) < NUM_WARPS);
    assign issue_valid     = grant_v;
    assign issue_warp      = grant_idx;
    assign barrier_release = any_waiting && !any_active;
    assign refill_req      = all_inactive;
    assign err_sticky      = cur_q.err;

    always_comb begin
        nxt_d = cur_q;
        if (evt_barrier && evt_exit) nxt_d.err = 1'b1;

        if (launch_valid) begin
            for (int i = 0; i < NUM_WARPS; i++) begin
                nxt_d.st[i] = launch_mask[i] ? WS_ACTIVE : WS_INACTIVE;
            end
            nxt_d.ptr = '0;
        end else if (barrier_release) begin
            for (int i = 0; i < NUM_WARPS; i++) begin
                if (cur_q.st[i] == WS_WAITING) nxt_d.st[i] = WS_ACTIVE;
            end
        end else begin
            if (evt_in_range && cur_q.st[evt_warp] == WS_ACTIVE) begin
                if (evt_exit)         nxt_d.st[evt_warp] = WS_INACTIVE;
                else if (evt_barrier) nxt_d.st[evt_warp] = WS_WAITING;
            end
            if (grant_v) begin
                if (int'(grant_idx) == NUM_WARPS - 1) nxt_d.ptr = '0;
                else                                  nxt_d.ptr = grant_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st  <= '0;
            cur_q.ptr <= '0;
            cur_q.err <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/ws_sched_chk.sv
module ws_sched_chk
    import ws_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             launch_valid,
    input logic [IDX_W-1:0] evt_warp,
    input logic             evt_barrier,
    input logic             evt_exit,
    input logic             issue_valid,
    input logic [IDX_W-1:0] issue_warp,
    input logic             barrier_release,
    input logic             refill_req,
    input logic             err_sticky,
    input logic [N-1:0][1:0] st_q
);
    // R3
    grant_is_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (st_q[issue_warp] == WS_ACTIVE));

    // R9
    refill_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> !issue_valid);

    // R10
    err_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R6
    release_regrants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (barrier_release && !launch_valid) |=> issue_valid);

    // R5
    barrier_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch_valid && evt_barrier && !evt_exit && int'(evt_warp) < N
         && st_q[evt_warp] == WS_ACTIVE) |=> (st_q[$past(evt_warp)] == WS_WAITING));
endmodule

bind ws_sched ws_sched_chk #(.N(NUM_WARPS), .IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .launch_valid    (launch_valid),
    .evt_warp        (evt_warp),
    .evt_barrier     (evt_barrier),
    .evt_exit        (evt_exit),
    .issue_valid     (issue_valid),
    .issue_warp      (issue_warp),
    .barrier_release (barrier_release),
    .refill_req      (refill_req),
    .err_sticky      (err_sticky),
    .st_q            (st_q)
);

// File: tb/ws_sched_tb.sv
module ws_sched_tb;
    localparam int NW = 8;
    localparam int IW = 3;
    localparam int S_IN = 0, S_ACT = 1, S_WAIT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          launch_valid = 1'b0;
    logic [NW-1:0] launch_mask = '0;
    logic [IW-1:0] evt_warp = '0;
    logic          evt_barrier = 1'b0, evt_exit = 1'b0;
    logic          issue_valid, barrier_release, refill_req, err_sticky;
    logic [IW-1:0] issue_warp;

    int checks = 0, failures = 0;
    int mst[NW];
    int mptr = 0;
    bit merr = 0;
    bit mg_v;
    int mg_w;

    always #10 clk = ~clk;

    ws_sched #(.NUM_WARPS(NW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_mask(launch_mask),
        .evt_warp(evt_warp), .evt_barrier(evt_barrier), .evt_exit(evt_exit),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .barrier_release(barrier_release), .refill_req(refill_req), .err_sticky(err_sticky)
    );

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    function automatic void model_grant();
        mg_v = 0; mg_w = 0;
        for (int off = NW - 1; off >= 0; off--) begin
            int s = (mptr + off) % NW;
            if (mst[s] == S_ACT) begin mg_v = 1; mg_w = s; end
        end
    endfunction

    function automatic bit m_rel();
        bit a = 0, w = 0;
        for (int i = 0; i < NW; i++) begin
            if (mst[i] == S_ACT) a = 1;
            if (mst[i] == S_WAIT) w = 1;
        end
        return w && !a;
    endfunction

    function automatic bit m_idle();
        for (int i = 0; i < NW; i++) if (mst[i] != S_IN) return 0;
        return 1;
    endfunction

    // Called just after a falling edge: compare, drive, advance model, wait.
    task automatic step(string tag, bit lv, logic [NW-1:0] lm, bit bar, bit ex, int w);
        bit rel;
        model_grant();
        rel = m_rel();
        chk(tag, "issue_valid (R3)", int'(issue_valid), int'(mg_v));
        if (mg_v) chk(tag, "issue_warp (R3)", int'(issue_warp), mg_w);
        chk(tag, "barrier_release (R6)", int'(barrier_release), int'(rel));
        chk(tag, "refill_req (R9)", int'(refill_req), int'(m_idle()));
        chk(tag, "err_sticky (R10)", int'(err_sticky), int'(merr));
        launch_valid = lv; launch_mask = lm;
        evt_barrier = bar; evt_exit = ex; evt_warp = IW'(w);
        if (bar && ex) merr = 1;
        if (lv) begin
            for (int i = 0; i < NW; i++) mst[i] = lm[i] ? S_ACT : S_IN;
            mptr = 0;
        end else if (rel) begin
            for (int i = 0; i < NW; i++) if (mst[i] == S_WAIT) mst[i] = S_ACT;
        end else begin
            if (w < NW && mst[w] == S_ACT) begin
                if (ex) mst[w] = S_IN;
                else if (bar) mst[w] = S_WAIT;
            end
            if (mg_v) mptr = (mg_w + 1) % NW;
        end
        @(posedge clk);
        @(negedge clk);
        launch_valid = 0; evt_barrier = 0; evt_exit = 0;
    endtask

    task automatic idle(string tag);
        step(tag, 0, '0, 0, 0, 0);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) mst[i] = S_IN;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle("R1");
        // R2: launch loads mask
        step("R2", 1, 8'b1011_0110, 0, 0, 0);
        // R4: rotation order over several cycles
        for (int k = 0; k < 10; k++) idle("R4");
        // R8: events for non-active slots (slot 0 inactive, index in range)
        step("R8", 0, '0, 1, 0, 0);
        step("R8", 0, '0, 0, 1, 3);
        idle("R8");
        // R5: park every granted warp at a barrier, then R6 release
        for (int k = 0; k < 6; k++) begin
            model_grant();
            if (mg_v) step("R5", 0, '0, 1, 0, mg_w); else idle("R6");
        end
        idle("R6");
        idle("R6");
        // R10: conflicting events on granted warp
        model_grant();
        step("R10", 0, '0, 1, 1, mg_w);
        idle("R10");
        // R7: retire all warps, then R9 refill
        for (int k = 0; k < 8; k++) begin
            model_grant();
            if (mg_v) step("R7", 0, '0, 0, 1, mg_w); else idle("R9");
        end
        idle("R9");
        // R2: launch overrides a simultaneous event; full mask
        step("R2", 1, 8'hFF, 1, 0, 0);
        idle("R2");
        // Mixed random traffic
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom_range(0, 99));
            model_grant();
            if (m_idle() && r < 50)
                step("R2", 1, NW'($urandom), 0, 0, 0);
            else if (mg_v && r < 15) step("R5", 0, '0, 1, 0, mg_w);
            else if (mg_v && r < 22) step("R7", 0, '0, 0, 1, mg_w);
            else if (r < 30) step("R8", 0, '0, r[0], !r[0], int'($urandom_range(0, NW - 1)));
            else if (r == 99) step("R10", 0, '0, 1, 1, int'($urandom_range(0, NW - 1)));
            else idle("R3");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule